// File: doc/BRIEF.md
# Privilege-Aware Register Bank Switcher

This block keeps the processor status word and the floating-point control word, together with the general register file R0 to R15 and two sets of sixteen floating-point registers. R0 to R7 exist twice. Which copy is in view depends on the privilege bit and the bank-select bit together. Writing the status word so that the visible copy changes exchanges the two copies of R0 to R7 in the same clock edge. Writing the floating-point control word so that its bank bit flips exchanges the two floating-point sets as a whole.

The execution pipeline reads registers through combinational read ports and writes them through single-cycle write ports. Separate ports reach the copy that is currently hidden, so that exception entry code can reach the other bank. Every port accepts on every cycle, so there is no handshake and no back-pressure. A write takes effect at the clock edge, and reads in the next cycle see the result. Individual condition flags can be updated through a flag port without rewriting the whole status word.

Top module: `rbank_switch`

## Requirements
- R1: After reset the status word reads 0x500000F0 (privilege=1, bank-select=0, block=1, interrupt mask=1111, all other bits 0). The floating-point control word reads 0. Every general, floating-point and hidden-bank register reads 0.
- R2: Only these status bits are kept: flag T at bit 0, flag S at bit 1, interrupt mask at bits 7:4, flag Q at bit 8, flag M at bit 9, block at bit 28, bank-select at bit 29 and privilege at bit 30. All other bits read 0. Only these control-word bits are kept: FR (bank) at bit 21, SZ at bit 20 and PR at bit 19. All other bits read 0.
- R3: The bank selector equals NOT bank-select when privilege is 1, and 0 when privilege is 0. A status write that changes the selector exchanges R0–R7 with the hidden copy at that clock edge, and reads in the next cycle return the exchanged values.
- R4: A status write that leaves the selector unchanged exchanges nothing. This includes a privilege change while bank-select is 1, and changes to the mask or block bits.
- R5: R8 to R15 are never exchanged.
- R6: A control-word write that flips FR exchanges all sixteen visible floating-point registers with the hidden set. A write that changes only SZ or PR exchanges nothing.
- R7: The flag port has a per-bit enable (enable bit 0 = T, 1 = S, 2 = Q, 3 = M) and never exchanges any bank. When a status write occurs in the same cycle, the status write wins and the flag update is dropped.
- R8: A register write issued in the same cycle as an exchanging control write lands in the view that existed before the exchange. After the edge it is found through the hidden-bank port.
- R9: The hidden-bank ports read and write the copy of R0–R7 that is not in view (3-bit index) and the floating-point set that is not in view (4-bit index).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sr_we | input | 1 | Status word write enable |
| sr_wdata | input | 32 | Status word write value |
| sr_rdata | output | 32 | Status word read value |
| flag_we | input | 4 | Per-flag enables: T, S, Q, M |
| flag_wval | input | 4 | Per-flag values, same order |
| fpcr_we | input | 1 | Floating-point control write enable |
| fpcr_wdata | input | 32 | Floating-point control write value |
| fpcr_rdata | output | 32 | Floating-point control read value |
| gpr_raddr | input | 4 | Visible general register read index |
| gpr_rdata | output | 32 | Visible general register read data |
| gpr_we | input | 1 | Visible general register write enable |
| gpr_waddr | input | 4 | Visible general register write index |
| gpr_wdata | input | 32 | Visible general register write data |
| alt_raddr | input | 3 | Hidden R0–R7 read index |
| alt_rdata | output | 32 | Hidden R0–R7 read data |
| alt_we | input | 1 | Hidden R0–R7 write enable |
| alt_waddr | input | 3 | Hidden R0–R7 write index |
| alt_wdata | input | 32 | Hidden R0–R7 write data |
| fpr_raddr | input | 4 | Visible FP register read index |
| fpr_rdata | output | 32 | Visible FP register read data |
| fpr_we | input | 1 | Visible FP register write enable |
| fpr_waddr | input | 4 | Visible FP register write index |
| fpr_wdata | input | 32 | Visible FP register write data |
| falt_raddr | input | 4 | Hidden FP register read index |
| falt_rdata | output | 32 | Hidden FP register read data |
| falt_we | input | 1 | Hidden FP register write enable |
| falt_waddr | input | 4 | Hidden FP register write index |
| falt_wdata | input | 32 | Hidden FP register write data |

## Verification
The hardest case to reach is a register write, a hidden-bank write and an exchanging status write that all fall on one clock edge. Only that case shows whether the writes are merged before or after the copy. The stimulus first loads distinct values into both copies of R0–R7. It then raises all three enables in a single cycle and reads the target index from both the visible and the hidden port. A matching case flips FR while writing a visible floating-point register. The cases where the selector stays put are reached by moving privilege while bank-select is already 1, so that the status word changes but the visible bank does not.

// File: rtl/rbank_pkg.sv
package rbank_pkg;
  localparam int SR_T  = 0;
  localparam int SR_S  = 1;
  localparam int SR_Q  = 8;
  localparam int SR_M  = 9;
  localparam int SR_BL = 28;
  localparam int SR_RB = 29;
  localparam int SR_MD = 30;
  localparam logic [31:0] SR_KEEP  = 32'h7000_03F3;
  localparam logic [31:0] SR_RESET = 32'h5000_00F0;

  localparam int FC_PR = 19;
  localparam int FC_SZ = 20;
  localparam int FC_FR = 21;
  localparam logic [31:0] FC_KEEP = 32'h0038_0000;

  localparam int NFLAG = 4;

  // Which physical slot backs the visible R0..R7 copy
  function automatic logic bank_sel(input logic [31:0] sr);
    return sr[SR_MD] ? ~sr[SR_RB] : 1'b0;
  endfunction
endpackage

// File: rtl/rbank_ctrl.sv
module rbank_ctrl
  import rbank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sr_we,
  input  logic [31:0]      sr_wdata,
  input  logic [NFLAG-1:0] flag_we,
  input  logic [NFLAG-1:0] flag_wval,
  input  logic             fpcr_we,
  input  logic [31:0]      fpcr_wdata,
  output logic [31:0]      sr_q,
  output logic [31:0]      fpcr_q,
  output logic             sel_cur,
  output logic             sel_new,
  output logic             gpr_swap,
  output logic             fr_cur
);
  localparam int FLAG_POS [NFLAG] = '{SR_T, SR_S, SR_Q, SR_M};

  logic [31:0] sr_nx;

  always_comb begin
    sr_nx = sr_q;
    if (sr_we) begin
      sr_nx = sr_wdata & SR_KEEP;
    end else begin
      for (int k = 0; k < NFLAG; k++)
        if (flag_we[k]) sr_nx[FLAG_POS[k]] = flag_wval[k];
    end
  end

  assign sel_cur  = bank_sel(sr_q);
  assign sel_new  = bank_sel(sr_nx);
  assign gpr_swap = sel_cur != sel_new;
  assign fr_cur   = fpcr_q[FC_FR];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q   <= SR_RESET;
      fpcr_q <= '0;
    end else begin
      sr_q <= sr_nx;
      if (fpcr_we) fpcr_q <= fpcr_wdata & FC_KEEP;
    end
  end
endmodule

// File: rtl/rbank_gpr.sv
module rbank_gpr #(
  parameter int XLEN    = 32,
  parameter int NREG    = 16,
  parameter int NBANKED = 8,
  localparam int AW = $clog2(NREG),
  localparam int BW = $clog2(NBANKED)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel_cur,
  input  logic            sel_new,
  input  logic            swap,
  input  logic [AW-1:0]   raddr,
  output logic [XLEN-1:0] rdata,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [BW-1:0]   alt_raddr,
  output logic [XLEN-1:0] alt_rdata,
  input  logic            alt_we,
  input  logic [BW-1:0]   alt_waddr,
  input  logic [XLEN-1:0] alt_wdata
);
  logic [XLEN-1:0] cur   [NREG];
  logic [XLEN-1:0] cur_n [NREG];
  logic [XLEN-1:0] shd   [2][NBANKED];
  logic [XLEN-1:0] shd_n [2][NBANKED];

  // Writes merge into the pre-exchange view, then the exchange copies
  always_comb begin
    cur_n = cur;
    shd_n = shd;
    if (we) cur_n[waddr] = wdata;
    if (alt_we) shd_n[~sel_cur][alt_waddr] = alt_wdata;
    if (swap) begin
      for (int i = 0; i < NBANKED; i++) begin
        shd_n[sel_cur][i] = cur_n[i];
        cur_n[i]          = shd_n[sel_new][i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) cur[i] <= '0;
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < NBANKED; i++) shd[b][i] <= '0;
    end else begin
      cur <= cur_n;
      shd <= shd_n;
    end
  end

  assign rdata     = cur[raddr];
  assign alt_rdata = shd[~sel_cur][alt_raddr];
endmodule

// File: rtl/rbank_fpr.sv
module rbank_fpr #(
  parameter int XLEN = 32,
  parameter int NF   = 16,
  localparam int AW = $clog2(NF)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            act,
  input  logic [AW-1:0]   raddr,
  output logic [XLEN-1:0] rdata,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [AW-1:0]   alt_raddr,
  output logic [XLEN-1:0] alt_rdata,
  input  logic            alt_we,
  input  logic [AW-1:0]   alt_waddr,
  input  logic [XLEN-1:0] alt_wdata
);
  logic [XLEN-1:0] phys [2][NF];

  // The exchange is a change of the active slot index (act)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < NF; i++) phys[b][i] <= '0;
    end else begin
      if (we)     phys[act][waddr]      <= wdata;
      if (alt_we) phys[~act][alt_waddr] <= alt_wdata;
    end
  end

  assign rdata     = phys[act][raddr];
  assign alt_rdata = phys[~act][alt_raddr];
endmodule

// File: rtl/rbank_switch.sv
module rbank_switch
  import rbank_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int NGPR    = 16,
  parameter int NBANKED = 8,
  parameter int NFPR    = 16,
  localparam int GAW = $clog2(NGPR),
  localparam int BAW = $clog2(NBANKED),
  localparam int FAW = $clog2(NFPR)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sr_we,
  input  logic [31:0]     sr_wdata,
  output logic [31:0]     sr_rdata,
  input  logic [3:0]      flag_we,
  input  logic [3:0]      flag_wval,
  input  logic            fpcr_we,
  input  logic [31:0]     fpcr_wdata,
  output logic [31:0]     fpcr_rdata,
  input  logic [GAW-1:0]  gpr_raddr,
  output logic [XLEN-1:0] gpr_rdata,
  input  logic            gpr_we,
  input  logic [GAW-1:0]  gpr_waddr,
  input  logic [XLEN-1:0] gpr_wdata,
  input  logic [BAW-1:0]  alt_raddr,
  output logic [XLEN-1:0] alt_rdata,
  input  logic            alt_we,
  input  logic [BAW-1:0]  alt_waddr,
  input  logic [XLEN-1:0] alt_wdata,
  input  logic [FAW-1:0]  fpr_raddr,
  output logic [XLEN-1:0] fpr_rdata,
  input  logic            fpr_we,
  input  logic [FAW-1:0]  fpr_waddr,
  input  logic [XLEN-1:0] fpr_wdata,
  input  logic [FAW-1:0]  falt_raddr,
  output logic [XLEN-1:0] falt_rdata,
  input  logic            falt_we,
  input  logic [FAW-1:0]  falt_waddr,
  input  logic [XLEN-1:0] falt_wdata
);
  logic sel_cur, sel_new, gpr_swap, fr_cur;

  rbank_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .sr_we(sr_we), .sr_wdata(sr_wdata),
    .flag_we(flag_we), .flag_wval(flag_wval),
    .fpcr_we(fpcr_we), .fpcr_wdata(fpcr_wdata),
    .sr_q(sr_rdata), .fpcr_q(fpcr_rdata),
    .sel_cur(sel_cur), .sel_new(sel_new),
    .gpr_swap(gpr_swap), .fr_cur(fr_cur)
  );

  rbank_gpr #(.XLEN(XLEN), .NREG(NGPR), .NBANKED(NBANKED)) u_gpr (
    .clk(clk), .rst_n(rst_n),
    .sel_cur(sel_cur), .sel_new(sel_new), .swap(gpr_swap),
    .raddr(gpr_raddr), .rdata(gpr_rdata),
    .we(gpr_we), .waddr(gpr_waddr), .wdata(gpr_wdata),
    .alt_raddr(alt_raddr), .alt_rdata(alt_rdata),
    .alt_we(alt_we), .alt_waddr(alt_waddr), .alt_wdata(alt_wdata)
  );

  rbank_fpr #(.XLEN(XLEN), .NF(NFPR)) u_fpr (
    .clk(clk), .rst_n(rst_n), .act(fr_cur),
    .raddr(fpr_raddr), .rdata(fpr_rdata),
    .we(fpr_we), .waddr(fpr_waddr), .wdata(fpr_wdata),
    .alt_raddr(falt_raddr), .alt_rdata(falt_rdata),
    .alt_we(falt_we), .alt_waddr(falt_waddr), .alt_wdata(falt_wdata)
  );
endmodule

// File: rtl/rbank_switch_chk.sv
module rbank_switch_chk
  import rbank_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int NGPR    = 16,
  parameter int NBANKED = 8,
  parameter int NFPR    = 16,
  localparam int GAW = $clog2(NGPR),
  localparam int BAW = $clog2(NBANKED),
  localparam int FAW = $clog2(NFPR)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sr_we,
  input logic [31:0]     sr_wdata,
  input logic [31:0]     sr_rdata,
  input logic [31:0]     fpcr_we_dummy_unused_n,
  input logic            fpcr_we,
  input logic [31:0]     fpcr_wdata,
  input logic [31:0]     fpcr_rdata,
  input logic [GAW-1:0]  gpr_raddr,
  input logic [XLEN-1:0] gpr_rdata,
  input logic            gpr_we,
  input logic [BAW-1:0]  alt_raddr,
  input logic [XLEN-1:0] alt_rdata,
  input logic            alt_we,
  input logic [FAW-1:0]  fpr_raddr,
  input logic [XLEN-1:0] fpr_rdata,
  input logic            fpr_we,
  input logic [FAW-1:0]  falt_raddr,
  input logic [XLEN-1:0] falt_rdata,
  input logic            falt_we
);
  logic sel_move;
  assign sel_move = sr_we && (bank_sel(sr_wdata & SR_KEEP) != bank_sel(sr_rdata));

  p_keep_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((sr_rdata & ~SR_KEEP) == '0) && ((fpcr_rdata & ~FC_KEEP) == '0));

  p_mode_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sr_we |=> sr_rdata[SR_MD:SR_RB] == $past(sr_rdata[SR_MD:SR_RB]));

  p_gpr_exchange_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_move && !gpr_we && !alt_we && gpr_raddr < GAW'(NBANKED) &&
     alt_raddr == gpr_raddr[BAW-1:0])
    |=> (!$stable(gpr_raddr) || !$stable(alt_raddr) ||
         (gpr_rdata == $past(alt_rdata) && alt_rdata == $past(gpr_rdata))));

  p_no_exchange_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_we && !sel_move && !gpr_we)
    |=> (!$stable(gpr_raddr) || $stable(gpr_rdata)));

  p_high_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (gpr_raddr >= GAW'(NBANKED) && !gpr_we)
    |=> (!$stable(gpr_raddr) || $stable(gpr_rdata)));

  p_fp_exchange_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fpcr_we && (fpcr_wdata[FC_FR] != fpcr_rdata[FC_FR]) && !fpr_we && !falt_we &&
     fpr_raddr == falt_raddr)
    |=> (!$stable(fpr_raddr) || !$stable(falt_raddr) ||
         (fpr_rdata == $past(falt_rdata) && falt_rdata == $past(fpr_rdata))));
endmodule

bind rbank_switch rbank_switch_chk #(
  .XLEN(XLEN), .NGPR(NGPR), .NBANKED(NBANKED), .NFPR(NFPR)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .sr_we(sr_we), .sr_wdata(sr_wdata), .sr_rdata(sr_rdata),
  .fpcr_we_dummy_unused_n(32'h0),
  .fpcr_we(fpcr_we), .fpcr_wdata(fpcr_wdata), .fpcr_rdata(fpcr_rdata),
  .gpr_raddr(gpr_raddr), .gpr_rdata(gpr_rdata), .gpr_we(gpr_we),
  .alt_raddr(alt_raddr), .alt_rdata(alt_rdata), .alt_we(alt_we),
  .fpr_raddr(fpr_raddr), .fpr_rdata(fpr_rdata), .fpr_we(fpr_we),
  .falt_raddr(falt_raddr), .falt_rdata(falt_rdata), .falt_we(falt_we)
);

// File: tb/rbank_switch_test.sv
`timescale 1ns/100ps
module rbank_switch_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sr_we, fpcr_we, gpr_we, alt_we, fpr_we, falt_we;
  logic [31:0] sr_wdata, fpcr_wdata, sr_rdata, fpcr_rdata;
  logic [3:0]  flag_we, flag_wval;
  logic [3:0]  gpr_raddr, gpr_waddr, fpr_raddr, fpr_waddr, falt_raddr, falt_waddr;
  logic [2:0]  alt_raddr, alt_waddr;
  logic [31:0] gpr_wdata, alt_wdata, fpr_wdata, falt_wdata;
  logic [31:0] gpr_rdata, alt_rdata, fpr_rdata, falt_rdata;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rbank_switch uut (
    .clk(clk), .rst_n(rst_n),
    .sr_we(sr_we), .sr_wdata(sr_wdata), .sr_rdata(sr_rdata),
    .flag_we(flag_we), .flag_wval(flag_wval),
    .fpcr_we(fpcr_we), .fpcr_wdata(fpcr_wdata), .fpcr_rdata(fpcr_rdata),
    .gpr_raddr(gpr_raddr), .gpr_rdata(gpr_rdata),
    .gpr_we(gpr_we), .gpr_waddr(gpr_waddr), .gpr_wdata(gpr_wdata),
    .alt_raddr(alt_raddr), .alt_rdata(alt_rdata),
    .alt_we(alt_we), .alt_waddr(alt_waddr), .alt_wdata(alt_wdata),
    .fpr_raddr(fpr_raddr), .fpr_rdata(fpr_rdata),
    .fpr_we(fpr_we), .fpr_waddr(fpr_waddr), .fpr_wdata(fpr_wdata),
    .falt_raddr(falt_raddr), .falt_rdata(falt_rdata),
    .falt_we(falt_we), .falt_waddr(falt_waddr), .falt_wdata(falt_wdata)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rd_g(input int a, output logic [31:0] v);
    @(negedge clk); gpr_raddr = 4'(a); #1; v = gpr_rdata;
  endtask
  task automatic rd_a(input int a, output logic [31:0] v);
    @(negedge clk); alt_raddr = 3'(a); #1; v = alt_rdata;
  endtask
  task automatic rd_f(input int a, output logic [31:0] v);
    @(negedge clk); fpr_raddr = 4'(a); #1; v = fpr_rdata;
  endtask
  task automatic rd_fa(input int a, output logic [31:0] v);
    @(negedge clk); falt_raddr = 4'(a); #1; v = falt_rdata;
  endtask

  task automatic wr_sr(input logic [31:0] v);
    @(negedge clk); sr_we = 1; sr_wdata = v;
    @(negedge clk); sr_we = 0;
  endtask
  task automatic wr_fc(input logic [31:0] v);
    @(negedge clk); fpcr_we = 1; fpcr_wdata = v;
    @(negedge clk); fpcr_we = 0;
  endtask
  task automatic wr_g(input int a, input logic [31:0] v);
    @(negedge clk); gpr_we = 1; gpr_waddr = 4'(a); gpr_wdata = v;
    @(negedge clk); gpr_we = 0;
  endtask
  task automatic wr_a(input int a, input logic [31:0] v);
    @(negedge clk); alt_we = 1; alt_waddr = 3'(a); alt_wdata = v;
    @(negedge clk); alt_we = 0;
  endtask
  task automatic wr_f(input int a, input logic [31:0] v);
    @(negedge clk); fpr_we = 1; fpr_waddr = 4'(a); fpr_wdata = v;
    @(negedge clk); fpr_we = 0;
  endtask
  task automatic wr_fa(input int a, input logic [31:0] v);
    @(negedge clk); falt_we = 1; falt_waddr = 4'(a); falt_wdata = v;
    @(negedge clk); falt_we = 0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    #1;
    chk("R1 status", sr_rdata, 32'h5000_00F0);
    chk("R1 fpcr", fpcr_rdata, 32'h0);
    rd_g(0, v);  chk("R1 r0", v, 0);
    rd_g(11, v); chk("R1 r11", v, 0);
    rd_a(3, v);  chk("R1 alt3", v, 0);
    rd_f(5, v);  chk("R1 fr5", v, 0);
    rd_fa(9, v); chk("R1 falt9", v, 0);
  endtask

  task automatic t_fields;
    wr_sr(32'hFFFF_FFFF);
    chk("R2 status mask", sr_rdata, 32'h7000_03F3);
    wr_sr(32'h5000_00F0);
    wr_fc(32'hFFFF_FFFF);
    chk("R2 fpcr mask", fpcr_rdata, 32'h0038_0000);
    wr_fc(32'h0);
    chk("R2 fpcr clear", fpcr_rdata, 32'h0);
  endtask

  task automatic t_gpr_swap;
    logic [31:0] v;
    for (int i = 0; i < 8; i++) wr_g(i, 32'h100 + i);
    for (int i = 0; i < 8; i++) wr_a(i, 32'h200 + i);
    wr_g(9, 32'h999);
    wr_sr(32'h7000_00F0);
    rd_g(0, v); chk("R3 r0 after swap", v, 32'h200);
    rd_g(7, v); chk("R3 r7 after swap", v, 32'h207);
    rd_a(5, v); chk("R9 alt5 holds old", v, 32'h105);
    rd_g(9, v); chk("R5 r9 unbanked", v, 32'h999);
  endtask

  task automatic t_noswap;
    logic [31:0] v;
    wr_sr(32'h3000_00F0);
    rd_g(2, v); chk("R4 md drop rb1", v, 32'h202);
    wr_sr(32'h0000_0030);
    rd_g(2, v); chk("R4 mask and bl", v, 32'h202);
    rd_a(2, v); chk("R4 alt unchanged", v, 32'h102);
    wr_sr(32'h5000_00F0);
    rd_g(2, v); chk("R3 back to slot1", v, 32'h102);
    rd_g(9, v); chk("R5 r9 again", v, 32'h999);
  endtask

  task automatic t_flags;
    logic [31:0] v;
    @(negedge clk); flag_we = 4'b1111; flag_wval = 4'b1111;
    @(negedge clk); flag_we = 4'b0000;
    chk("R7 flags set", sr_rdata, 32'h5000_03F3);
    rd_g(2, v); chk("R7 no swap", v, 32'h102);
    @(negedge clk); flag_we = 4'b0101; flag_wval = 4'b0000;
    @(negedge clk); flag_we = 4'b0000;
    chk("R7 clear T and Q", sr_rdata, 32'h5000_02F2);
    @(negedge clk); flag_we = 4'b1111; flag_wval = 4'b1111;
    sr_we = 1; sr_wdata = 32'h5000_00F0;
    @(negedge clk); flag_we = 4'b0000; sr_we = 0;
    chk("R7 status write wins", sr_rdata, 32'h5000_00F0);
  endtask

  task automatic t_overlap;
    logic [31:0] v;
    @(negedge clk);
    gpr_we = 1; gpr_waddr = 4; gpr_wdata = 32'hAAAA;
    alt_we = 1; alt_waddr = 4; alt_wdata = 32'hBBBB;
    sr_we  = 1; sr_wdata  = 32'h7000_00F0;
    @(negedge clk); gpr_we = 0; alt_we = 0; sr_we = 0;
    rd_g(4, v); chk("R8 visible after swap", v, 32'hBBBB);
    rd_a(4, v); chk("R8 hidden after swap", v, 32'hAAAA);
  endtask

  task automatic t_fp;
    logic [31:0] v;
    wr_f(0, 32'h300); wr_f(7, 32'h307); wr_f(15, 32'h30F);
    wr_fa(0, 32'h400); wr_fa(7, 32'h407); wr_fa(15, 32'h40F);
    wr_fc(32'h0018_0000);
    rd_f(7, v); chk("R6 sz pr no swap", v, 32'h307);
    wr_fc(32'h0020_0000);
    chk("R6 fpcr read", fpcr_rdata, 32'h0020_0000);
    rd_f(7, v);   chk("R6 fr7 swapped", v, 32'h407);
    rd_f(15, v);  chk("R6 fr15 swapped", v, 32'h40F);
    rd_fa(7, v);  chk("R9 falt7", v, 32'h307);
    @(negedge clk);
    fpr_we = 1; fpr_waddr = 0; fpr_wdata = 32'hCC;
    fpcr_we = 1; fpcr_wdata = 32'h0;
    @(negedge clk); fpr_we = 0; fpcr_we = 0;
    rd_f(0, v);  chk("R8 fp visible", v, 32'h300);
    rd_fa(0, v); chk("R8 fp hidden", v, 32'hCC);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    sr_we = 0; fpcr_we = 0; gpr_we = 0; alt_we = 0; fpr_we = 0; falt_we = 0;
    sr_wdata = 0; fpcr_wdata = 0; flag_we = 0; flag_wval = 0;
    gpr_raddr = 0; gpr_waddr = 0; gpr_wdata = 0;
    alt_raddr = 0; alt_waddr = 0; alt_wdata = 0;
    fpr_raddr = 0; fpr_waddr = 0; fpr_wdata = 0;
    falt_raddr = 0; falt_waddr = 0; falt_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_fields();
    t_gpr_swap();
    t_noswap();
    t_flags();
    t_overlap();
    t_fp();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule